// File: doc/BRIEF.md
# Latched I/O port bank

This block sits next to a small controller core and gives it three latched I/O ports and one sense input. Two ports are four bits wide. A third port has four latch bits, but only its two low bits reach pins. Each pin is an open-drain line with a pull-up. A latch bit of 1 lets the line float high, so the line can be read as an input. A latch bit of 0 pulls the line low. Latch bit 2 of the narrow port drives the hold line inside the block. That line also serves as the sense input and as the first interrupt source.

The core can work on a whole nibble at a time. It can also set, clear or test a single bit, using a five-bit index that spans the three ports. Every pin level is synchronized before it is read. The same synchronized levels feed falling-edge detectors. A falling edge on the hold line gives interrupt request 1. A falling edge on pin 0 of the narrow port gives interrupt request 2, but only while the interrupt enable bit is high.

Top module: `io_port_bank`

## Requirements
- R1: During and after reset, every latch bit is 1. This covers all bits of port A, port B and the four-bit narrow port C, so `pa_lat_o`, `pb_lat_o`, `pc_lat_o` and `hold_lat_o` all read 1.
- R2: When `nib_we_i` is high, the port chosen by `nib_addr_i` takes `nib_wdata_i` on the next clock edge. The codes are 0 = A, 1 = B and 2 = C, where C takes all four bits. Code 3 writes nothing.
- R3: A single-bit operation picks its target from the index value. Indexes 0 to 3 select A bits 0 to 3. Indexes 4 to 7 select B bits 0 to 3. Indexes 8 to 11 select C bits 0 to 3. `bit_set_i` writes a 1 and `bit_clr_i` writes a 0. If both are high, the clear wins. If a nibble write and a bit operation hit the same port in one cycle, the bit operation overrides the nibble data in its own bit.
- R4: A set or clear at an index of 12 or above changes no latch bit, and a test at such an index returns 0.
- R5: `bit_test_o` shows the chosen bit in the same cycle. For a bit with a pin (indexes 0 to 9), it returns the synchronized pin level. For the pinless bits (indexes 10 and 11), it returns the latch bit.
- R6: Nibble read codes 0 and 1 return the synchronized pin levels of A and B. Code 2 returns C latch bits 3:2 above the synchronized C pins 1:0. A pin change shows up in a read on the second clock edge after it happens.
- R7: Nibble read code 3 returns the inverse of the synchronized hold line in bit 0, and 0 in bits 3:1. `hold_lat_o` (C latch bit 2) drives the hold line low when it is 0.
- R8: Each falling edge on the synchronized hold line gives exactly one cycle of `irq1_o`, with no gating. The pulse comes in the cycle after the second synchronizer edge.
- R9: Each falling edge on synchronized C pin 0 gives one cycle of `irq2_o`, but only if `eir0_i` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nib_we_i | input | 1 | Nibble write strobe |
| nib_addr_i | input | 2 | Nibble port code (0 A, 1 B, 2 C, 3 sense) |
| nib_wdata_i | input | 4 | Nibble write data |
| nib_rdata_o | output | 4 | Nibble read data for `nib_addr_i` |
| bit_idx_i | input | 5 | Single-bit index |
| bit_set_i | input | 1 | Set the indexed latch bit |
| bit_clr_i | input | 1 | Clear the indexed latch bit |
| bit_test_o | output | 1 | Level of the indexed bit |
| pa_pin_i | input | 4 | Resolved levels of the port A lines |
| pa_lat_o | output | 4 | Port A latch (0 pulls the line low) |
| pb_pin_i | input | 4 | Resolved levels of the port B lines |
| pb_lat_o | output | 4 | Port B latch |
| pc_pin_i | input | 2 | Resolved levels of the port C lines |
| pc_lat_o | output | 2 | Port C latch bits 1:0 |
| hold_pin_i | input | 1 | Resolved level of the hold line |
| hold_lat_o | output | 1 | Port C latch bit 2, open-drain onto the hold line |
| eir0_i | input | 1 | Enable for interrupt request 2 |
| irq1_o | output | 1 | Hold-line falling-edge pulse |
| irq2_o | output | 1 | C pin 0 falling-edge pulse, gated |

## Verification
The bench goes after the index boundaries. A decoder that wraps index 12 onto port A would clear a real pin. A decoder that treats indexes 10 and 11 as pins would report a pin level instead of the pinless latch. The bench also drives set and clear together, and a nibble write together with a bit operation on the same port. A wrong priority leaves the latch at the wrong value on the next cycle.

The bench times pin reads and interrupts against the two-flop delay, so a missing or extra stage shows up as a miscompare. It clears latch bit 2 to check that the internal hold line raises interrupt request 1 and flips the sense bit. It toggles the enable around falling edges on C pin 0 to catch a request that fires while disabled, or that lasts longer than one cycle.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int NIB_W  = 4;
  localparam int IDX_W  = 5;
  localparam int NPORTS = 3;
  localparam int PC_PINS = 2;
  localparam int PIN_W  = 2 * NIB_W + PC_PINS + 1;
  localparam int HOLD_BIT = 2;

  typedef enum logic [1:0] {
    NIB_A     = 2'd0,
    NIB_B     = 2'd1,
    NIB_C     = 2'd2,
    NIB_SENSE = 2'd3
  } nib_sel_e;
endpackage

// File: rtl/port_latch.sv
module port_latch #(
  parameter int W = 4,
  localparam int SEL_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nib_we_i,
  input  logic [W-1:0]     nib_d_i,
  input  logic             bit_we_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             bit_val_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (nib_we_i) nxt = nib_d_i;
    // bit op overrides nibble data in its own bit
    if (bit_we_i) nxt[bit_sel_i] = bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '1;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 11,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  // reset to pulled-up idle so no false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st[0] <= '1;
    else         st[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[s] <= '1;
      else         st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/edge_fall.sv
module edge_fall #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  assign pulse_o = prev_q & ~lvl_i & en_i;
endmodule

// File: rtl/io_port_bank.sv
module io_port_bank
  import io_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nib_we_i,
  input  logic [1:0]       nib_addr_i,
  input  logic [NIB_W-1:0] nib_wdata_i,
  output logic [NIB_W-1:0] nib_rdata_o,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_set_i,
  input  logic             bit_clr_i,
  output logic             bit_test_o,
  input  logic [NIB_W-1:0] pa_pin_i,
  output logic [NIB_W-1:0] pa_lat_o,
  input  logic [NIB_W-1:0] pb_pin_i,
  output logic [NIB_W-1:0] pb_lat_o,
  input  logic [PC_PINS-1:0] pc_pin_i,
  output logic [PC_PINS-1:0] pc_lat_o,
  input  logic             hold_pin_i,
  output logic             hold_lat_o,
  input  logic             eir0_i,
  output logic             irq1_o,
  output logic             irq2_o
);
  localparam int SEL_W = $clog2(NIB_W);
  localparam int HOLD_POS = PIN_W - 1;
  localparam int PC0_POS = 2 * NIB_W;

  logic [NIB_W-1:0] lat [NPORTS];
  logic [PIN_W-1:0] pin_raw, pin_s;
  logic [1:0]       irq_vec;
  logic             bit_op;
  logic [IDX_W-SEL_W-1:0] idx_port;
  logic [SEL_W-1:0] idx_sel;

  assign bit_op   = bit_set_i | bit_clr_i;
  assign idx_port = bit_idx_i[IDX_W-1:SEL_W];
  assign idx_sel  = bit_idx_i[SEL_W-1:0];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_latch #(.W(NIB_W)) u_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .nib_we_i  (nib_we_i && (nib_addr_i == 2'(p))),
      .nib_d_i   (nib_wdata_i),
      .bit_we_i  (bit_op && (idx_port == (IDX_W-SEL_W)'(p))),
      .bit_sel_i (idx_sel),
      .bit_val_i (~bit_clr_i),
      .q_o       (lat[p])
    );
  end

  assign pa_lat_o   = lat[0];
  assign pb_lat_o   = lat[1];
  assign pc_lat_o   = lat[2][PC_PINS-1:0];
  assign hold_lat_o = lat[2][HOLD_BIT];

  assign pin_raw = {hold_pin_i, pc_pin_i, pb_pin_i, pa_pin_i};

  pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw),
    .q_o    (pin_s)
  );

  edge_fall #(.W(2)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   ({pin_s[PC0_POS], pin_s[HOLD_POS]}),
    .en_i    ({eir0_i, 1'b1}),
    .pulse_o (irq_vec)
  );

  assign irq1_o = irq_vec[0];
  assign irq2_o = irq_vec[1];

  always_comb begin
    unique case (nib_sel_e'(nib_addr_i))
      NIB_A:   nib_rdata_o = pin_s[NIB_W-1:0];
      NIB_B:   nib_rdata_o = pin_s[2*NIB_W-1:NIB_W];
      NIB_C:   nib_rdata_o = {lat[2][NIB_W-1:PC_PINS], pin_s[PC0_POS +: PC_PINS]};
      default: nib_rdata_o = {{(NIB_W-1){1'b0}}, ~pin_s[HOLD_POS]};
    endcase
  end

  always_comb begin
    case (idx_port)
      (IDX_W-SEL_W)'(0): bit_test_o = pin_s[idx_sel];
      (IDX_W-SEL_W)'(1): bit_test_o = pin_s[NIB_W + int'(idx_sel)];
      (IDX_W-SEL_W)'(2): bit_test_o = (int'(idx_sel) < PC_PINS) ?
                                      pin_s[PC0_POS + int'(idx_sel)] : lat[2][idx_sel];
      default:           bit_test_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/io_port_bank_chk.sv
module io_port_bank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nib_we_i,
  input logic [1:0] nib_addr_i,
  input logic [3:0] nib_wdata_i,
  input logic [3:0] nib_rdata_o,
  input logic [4:0] bit_idx_i,
  input logic       bit_set_i,
  input logic       bit_clr_i,
  input logic       bit_test_o,
  input logic [3:0] pa_lat_o,
  input logic [3:0] pb_lat_o,
  input logic [1:0] pc_lat_o,
  input logic       hold_lat_o,
  input logic       eir0_i,
  input logic       irq1_o,
  input logic       irq2_o
);
  assert_nib_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_we_i && nib_addr_i == 2'd0 &&
     !((bit_set_i || bit_clr_i) && bit_idx_i[4:2] == 3'd0))
    |=> pa_lat_o == $past(nib_wdata_i));

  assert_bit_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_clr_i && bit_idx_i < 5'd4) |=> !pa_lat_o[$past(bit_idx_i[1:0])]);

  assert_bad_idx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bit_set_i || bit_clr_i) && bit_idx_i >= 5'd12 && !nib_we_i)
    |=> $stable({pa_lat_o, pb_lat_o, pc_lat_o, hold_lat_o}));

  assert_bad_idx_test_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_idx_i >= 5'd12) |-> !bit_test_o);

  assert_sense_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_addr_i == 2'd3) |-> nib_rdata_o[3:1] == 3'b000);

  assert_irq1_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |=> !irq1_o);

  assert_irq2_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq2_o |-> eir0_i);

  assert_irq2_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq2_o |=> !irq2_o);
endmodule

bind io_port_bank io_port_bank_chk u_chk (.*);

// File: tb/io_port_bank_test.sv
`timescale 1ns/1ps
module io_port_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       nib_we = 0, bit_set = 0, bit_clr = 0, eir0 = 0;
  logic [1:0] nib_addr = 0;
  logic [3:0] nib_wdata = 0;
  logic [4:0] bit_idx = 0;
  logic [3:0] ext_a = '1, ext_b = '1;
  logic [1:0] ext_c = '1;
  logic       ext_h = 1'b1;

  logic [3:0] nib_rdata, pa_lat, pb_lat, pa_pin, pb_pin;
  logic [1:0] pc_lat, pc_pin;
  logic bit_test, hold_lat, hold_pin, irq1, irq2;

  // open-drain wired-AND of latch and external driver
  assign pa_pin = pa_lat & ext_a;
  assign pb_pin = pb_lat & ext_b;
  assign pc_pin = pc_lat & ext_c;
  assign hold_pin = hold_lat & ext_h;

  io_port_bank uut (
    .clk_i(clk), .rst_ni(rst_n),
    .nib_we_i(nib_we), .nib_addr_i(nib_addr), .nib_wdata_i(nib_wdata),
    .nib_rdata_o(nib_rdata),
    .bit_idx_i(bit_idx), .bit_set_i(bit_set), .bit_clr_i(bit_clr),
    .bit_test_o(bit_test),
    .pa_pin_i(pa_pin), .pa_lat_o(pa_lat),
    .pb_pin_i(pb_pin), .pb_lat_o(pb_lat),
    .pc_pin_i(pc_pin), .pc_lat_o(pc_lat),
    .hold_pin_i(hold_pin), .hold_lat_o(hold_lat),
    .eir0_i(eir0), .irq1_o(irq1), .irq2_o(irq2)
  );

  int checks = 0, fails = 0;
  bit in_reset = 1'b1;

  // reference model state
  logic [3:0]  m_a = '1, m_b = '1, m_c = '1;
  logic [10:0] m_s1 = '1, m_s2 = '1;
  logic        m_ph = 1'b1, m_pc = 1'b1;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string lt, tt, rt;
    logic [3:0] e_rd;
    logic e_tst;
    int i;
    i = int'(bit_idx);
    lt = in_reset ? "R1" : ((bit_set || bit_clr) ? (i >= 12 ? "R4" : "R3") : "R2");
    chk(lt, "pa_lat", pa_lat, m_a);
    chk(lt, "pb_lat", pb_lat, m_b);
    chk(lt, "pc_lat", pc_lat, m_c[1:0]);
    chk(lt, "hold_lat", hold_lat, m_c[2]);
    case (nib_addr)
      2'd0: e_rd = m_s2[3:0];
      2'd1: e_rd = m_s2[7:4];
      2'd2: e_rd = {m_c[3:2], m_s2[9:8]};
      default: e_rd = {3'b000, ~m_s2[10]};
    endcase
    rt = (nib_addr == 2'd3) ? "R7" : "R6";
    chk(rt, "nib_rdata", nib_rdata, e_rd);
    if (i <= 9) e_tst = m_s2[i];
    else if (i <= 11) e_tst = m_c[i-8];
    else e_tst = 1'b0;
    tt = (i >= 12) ? "R4" : "R5";
    chk(tt, "bit_test", bit_test, e_tst);
    chk("R8", "irq1", irq1, m_ph & ~m_s2[10]);
    chk("R9", "irq2", irq2, m_pc & ~m_s2[8] & eir0);
  endtask

  task automatic step();
    logic [10:0] pins;
    logic [3:0] na, nb, nc;
    int i;
    #1 compare();
    @(posedge clk);
    pins = {m_c[2] & ext_h, m_c[1:0] & ext_c, m_b & ext_b, m_a & ext_a};
    na = m_a; nb = m_b; nc = m_c;
    if (rst_n) begin
      if (nib_we) begin
        if (nib_addr == 2'd0) na = nib_wdata;
        else if (nib_addr == 2'd1) nb = nib_wdata;
        else if (nib_addr == 2'd2) nc = nib_wdata;
      end
      if (bit_set || bit_clr) begin
        i = int'(bit_idx);
        if (i < 4) na[i] = ~bit_clr;
        else if (i < 8) nb[i-4] = ~bit_clr;
        else if (i < 12) nc[i-8] = ~bit_clr;
      end
      m_ph = m_s2[10]; m_pc = m_s2[8];
      m_s2 = m_s1; m_s1 = pins;
      m_a = na; m_b = nb; m_c = nc;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    nib_we = 0; bit_set = 0; bit_clr = 0;
  endtask

  task automatic bitop(int idx, bit s, bit c);
    bit_idx = 5'(idx); bit_set = s; bit_clr = c; nib_we = 0;
    step();
    idle(); step();
  endtask

  task automatic nibw(int a, int d);
    nib_addr = 2'(a); nib_wdata = 4'(d); nib_we = 1;
    step();
    idle(); step();
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();                 // R1 in reset
    rst_n = 1'b1; in_reset = 1'b0;
    for (int k = 0; k < 3; k++) step();

    // R2 nibble writes
    nibw(0, 4'h5); nibw(1, 4'hA); nibw(2, 4'h3);
    for (int k = 0; k < 3; k++) begin nib_addr = 2'(k); step(); end
    nibw(0, 4'hF); nibw(1, 4'hF); nibw(2, 4'hF);

    // R3 index clear of A3 (index 00011), set back, set+clr together
    bitop(3, 0, 1); bitop(3, 1, 0); bitop(6, 1, 1); bitop(6, 1, 0);
    bitop(9, 0, 1); bitop(11, 0, 1);
    bit_idx = 5'd11; step(); step(); // R5 pinless readback
    bitop(11, 1, 0); bitop(9, 1, 0);
    // nibble write and bit op on same port
    nib_addr = 2'd0; nib_wdata = 4'h0; nib_we = 1; bit_idx = 5'd1; bit_set = 1;
    step(); idle(); step();
    nibw(0, 4'hF);

    // R4 out-of-range indexes
    for (int k = 12; k < 32; k += 5) begin bitop(k, 0, 1); bitop(k, 1, 0); end

    // R6/R5 external pin pulls
    nib_addr = 2'd1; bit_idx = 5'd5;
    ext_b = 4'b1101; for (int k = 0; k < 4; k++) step();
    ext_b = '1; for (int k = 0; k < 4; k++) step();

    // R7/R8 hold line via external pin and via latch bit 2 (index 10)
    nib_addr = 2'd3;
    ext_h = 0; for (int k = 0; k < 5; k++) step();
    ext_h = 1; for (int k = 0; k < 4; k++) step();
    bitop(10, 0, 1); for (int k = 0; k < 4; k++) step();
    bitop(10, 1, 0); for (int k = 0; k < 4; k++) step();

    // R9 gated C pin 0 edges
    nib_addr = 2'd2; eir0 = 0;
    ext_c = 2'b10; for (int k = 0; k < 5; k++) step();
    ext_c = 2'b11; for (int k = 0; k < 3; k++) step();
    eir0 = 1;
    ext_c = 2'b10; for (int k = 0; k < 5; k++) step();
    ext_c = 2'b11; for (int k = 0; k < 3; k++) step();
    bitop(8, 0, 1); for (int k = 0; k < 4; k++) step();
    bitop(8, 1, 0);

    // mixed stimulus
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      nib_we = (r[2:0] == 3'd0); nib_addr = r[4:3]; nib_wdata = r[8:5];
      bit_idx = r[13:9]; bit_set = r[14]; bit_clr = r[15] & r[16];
      eir0 = r[17]; ext_a = r[21:18] | 4'(r[22] ? 4'hF : 4'h0);
      ext_b = r[26:23] | 4'(r[27] ? 4'hF : 4'h0);
      ext_c = r[29:28] | {2{r[30]}}; ext_h = r[31] | r[0];
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule